// File: doc/BRIEF.md
# Power-Fail Guarded Byte Memory

This block is a 2048-byte storage array with an active-low, SRAM-like control interface: a chip select, an output enable and a write strobe, an 11-bit address, and a data bus split into an input byte, an output byte and an output-drive flag. Every control input is sampled on the block clock. A write is committed at a rising edge, and read data follows the address within the same cycle.

Two digital status inputs from a supply monitor protect the contents. While `power_good` is low, the block turns into a dead load. It drives nothing, stores nothing and ignores every control, address and data input. Once the supply returns, a recovery window of a set number of clock cycles has to pass before commands are accepted again. At the moment power is restored, the block samples `battery_low`. If that input is high, a battery-warning flag is set. The flag discards the next accepted write without any signal and then clears itself. Software finds a weak backup cell by writing a byte's complement back and reading it again. The array has no reset, so its contents survive both supply dips and control resets.

Top module: `guarded_byte_ram`

## Requirements
- R1: When the block is live, `ce_n`=0, `we_n`=1 and `oe_n`=0, `dq_oe` is 1 and `dq_out` shows the byte stored at `addr` in the same cycle. In any other case `dq_oe` is 0 and `dq_out` is 8'h00.
- R2: When the block is live and `ce_n`=0 and `we_n`=0 at a rising edge, `dq_in` is stored at `addr`, whatever the value of `oe_n`. During such a cycle `dq_oe` is 0.
- R3: With `ce_n`=1, nothing is stored and `dq_oe` is 0, whatever `we_n`, `oe_n`, `addr` and `dq_in` are.
- R4: While `power_good` is 0, `dq_oe` is 0 and no write is committed, whatever the control, address and data inputs are.
- R5: After `power_good` goes from 0 to 1, or after reset ends, the block is live only from the RECOVER_CYC-th rising edge (default 16) at which `power_good` has been sampled high without a break. Accesses made before that edge store nothing and drive nothing.
- R6: `battery_low` is sampled only at the first rising edge with `power_good` high after it was low, or after reset. If it is 1 there, the next accepted write leaves memory unchanged. While powered, `battery_low` has no effect.
- R7: The first accepted write after a blocked one clears nothing further. It and every later write store normally.
- R8: While the battery-warning flag is set, reads return the stored bytes unchanged.
- R9: A supply drop, including one that arrives together with a write request, leaves every location unchanged.
- R10: During and just after reset, `dq_oe` is 0. Reset does not clear the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset of the control state (not the array) |
| power_good | input | 1 | Supply above deselect threshold when 1 |
| battery_low | input | 1 | Backup cell weak; sampled on supply restore |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 11 | Byte address |
| dq_in | input | 8 | Write data |
| dq_out | output | 8 | Read data, zero when not driving |
| dq_oe | output | 1 | Output drive enable for the data bus |

## Verification
The hardest state to reach is the battery-warning flag. It comes only from a supply restore that coincides with a high `battery_low`, and its effect is a write that is silently dropped, with no output to show it. The stimulus first drops `power_good`, then raises it with `battery_low` held high for that single edge, and waits out the recovery window. It reads a byte while the flag is set, writes a new value and reads it back unchanged, then writes again and sees the new value stored. The recovery boundary is probed one cycle before and exactly at the edge where the block goes live, and a write attempted inside the window is shown to have left memory untouched.

// File: rtl/gbr_pkg.sv
// Package: shared types for the guarded byte memory.
// Assumes: nothing beyond IEEE 1800-2017.
package gbr_pkg;
    // Decoded kind of bus access for one cycle.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/gbr_power_seq.sv
// Module: gbr_power_seq
// Tracks supply state. Holds a recovery countdown after supply restore or reset,
// and keeps the battery-warning flag that swallows one write.
// Assumes: power_good and battery_low are already synchronised to clk; RECOVER_CYC >= 1.
module gbr_power_seq #(
    parameter int RECOVER_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic power_good,
    input  logic battery_low,
    input  logic wr_attempt_i,
    output logic live_o,
    output logic block_o
);
    localparam int CNT_W = $clog2(RECOVER_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RECOVER_CYC);

    logic             pg_q;
    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic             restore;

    // Detect the first powered edge after an outage or after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pg_q <= 1'b0;
        else        pg_q <= power_good;
    end

    assign restore = power_good && !pg_q;

    // Recovery countdown: reloads while unpowered or in reset, runs down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !power_good) cnt_q <= CNT_LOAD;
        else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
    end

    // Battery-warning flag: set on restore from battery_low, cleared by one accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)            flag_q <= 1'b0;
        else if (restore)      flag_q <= battery_low;
        else if (wr_attempt_i) flag_q <= 1'b0;
    end

    assign live_o  = power_good && (cnt_q == '0);
    assign block_o = flag_q;

    // R5: the block is never live on the edge where the supply comes back.
    a_r5_closed_on_restore: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(power_good) |-> !live_o);

    // R6: one accepted write attempt always consumes the flag.
    a_r6_flag_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && wr_attempt_i) |=> !flag_q);

    // R6: the flag only rises at a restore edge.
    a_r6_flag_rises_on_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !restore) |=> !flag_q);
endmodule

// File: rtl/gbr_access_ctl.sv
// Module: gbr_access_ctl
// Decodes the active-low strobes into read, write or idle. Gates them with the live state
// and the battery-warning flag.
// Assumes: strobes are sampled synchronously; a write wins over a read when both are selected.
module gbr_access_ctl
    import gbr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic live_i,
    input  logic block_i,
    output logic wr_attempt_o,
    output logic wr_en_o,
    output logic drive_o
);
    acc_kind_e kind;

    // Classify this cycle's access.
    always_comb begin
        if (!live_i || ce_n) kind = ACC_IDLE;
        else if (!we_n)      kind = ACC_WRITE;
        else                 kind = ACC_READ;
    end

    // Derive the commit, attempt and drive strobes.
    always_comb begin
        wr_attempt_o = (kind == ACC_WRITE);
        wr_en_o      = (kind == ACC_WRITE) && !block_i;
        drive_o      = (kind == ACC_READ) && !oe_n;
    end

    // R2: the bus is never driven while the write strobe is low.
    a_r2_quiet_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !drive_o);

    // R3: a deselected chip neither drives nor writes.
    a_r3_standby: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !(drive_o || wr_en_o || wr_attempt_o));

    // R6: a flagged write is never committed.
    a_r6_blocked_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        block_i |-> !wr_en_o);
endmodule

// File: rtl/gbr_store.sv
// Module: gbr_store
// Byte array with one synchronous write port and one combinational read port. It has no reset.
// Assumes: the caller gates wr_en_i; the contents are undefined until written.
module gbr_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Commit one byte per accepted write.
    always_ff @(posedge clk) begin
        if (wr_en_i) mem[addr_i] <= wdata_i;
    end

    // Ripple-through read of the addressed byte.
    assign rdata_o = mem[addr_i];
endmodule

// File: rtl/guarded_byte_ram.sv
// Module: guarded_byte_ram (top)
// A 2^ADDR_W x DATA_W memory with active-low SRAM-style strobes. It is dead while the
// supply is bad, waits out a recovery window after restore, and drops one write when
// the backup cell was flagged weak.
// Assumes: all inputs are synchronous to clk; rst_n is synchronous, active low.
module guarded_byte_ram #(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int RECOVER_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              power_good,
    input  logic              battery_low,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    logic              live;
    logic              block;
    logic              wr_attempt;
    logic              wr_en;
    logic              drive;
    logic [DATA_W-1:0] rdata;

    gbr_power_seq #(
        .RECOVER_CYC (RECOVER_CYC)
    ) pwr_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .power_good   (power_good),
        .battery_low  (battery_low),
        .wr_attempt_i (wr_attempt),
        .live_o       (live),
        .block_o      (block)
    );

    gbr_access_ctl acc_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ce_n         (ce_n),
        .oe_n         (oe_n),
        .we_n         (we_n),
        .live_i       (live),
        .block_i      (block),
        .wr_attempt_o (wr_attempt),
        .wr_en_o      (wr_en),
        .drive_o      (drive)
    );

    gbr_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) mem_i (
        .clk     (clk),
        .wr_en_i (wr_en),
        .addr_i  (addr),
        .wdata_i (dq_in),
        .rdata_o (rdata)
    );

    // Present read data only while driving, so the bus reads zero otherwise.
    assign dq_oe  = drive;
    assign dq_out = drive ? rdata : '0;

    // R4: nothing is driven without supply.
    a_r4_dark_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
        !power_good |-> !dq_oe);

    // R4, R9: nothing is committed without supply.
    a_r9_no_commit_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
        !power_good |-> !wr_en);

    // R1: the bus is only driven for a selected read with the output enabled.
    a_r1_drive_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!ce_n && !oe_n && we_n));
endmodule

// File: tb/guarded_byte_ram_tb_top.sv
module guarded_byte_ram_tb_top;
    localparam int RC = 16;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          power_good = 1'b1;
    logic          battery_low = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    dq_in = '0;
    logic [7:0]    dq_out;
    logic          dq_oe;

    int tests = 0;
    int fails = 0;

    // Behavioural reference state.
    logic [7:0] ref_mem [2048];
    int         ref_rec = RC;
    bit         ref_flag = 0;
    bit         ref_pgprev = 0;

    guarded_byte_ram #(.ADDR_W(AW), .DATA_W(8), .RECOVER_CYC(RC)) dut_i (
        .clk(clk), .rst_n(rst_n), .power_good(power_good), .battery_low(battery_low),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] pat(int a);
        return 8'(a * 37 + 11);
    endfunction

    // Reference model update at each edge.
    always @(posedge clk) begin
        bit live_m;
        if (!rst_n) begin
            ref_rec = RC; ref_flag = 0; ref_pgprev = 0;
        end else begin
            live_m = power_good && (ref_rec == 0);
            if (live_m && !ce_n && !we_n) begin
                if (ref_flag) ref_flag = 0;
                else          ref_mem[addr] = dq_in;
            end
            if (power_good && !ref_pgprev) ref_flag = battery_low;
            if (!power_good)      ref_rec = RC;
            else if (ref_rec > 0) ref_rec = ref_rec - 1;
            ref_pgprev = power_good;
        end
    end

    // Compare outputs to the model in the middle of every cycle.
    always @(negedge clk) begin
        bit exp_oe;
        string tag;
        exp_oe = rst_n && power_good && (ref_rec == 0) && !ce_n && we_n && !oe_n;
        if (!rst_n) tag = "R10";
        else if (!power_good) tag = "R4";
        else if (ref_rec != 0) tag = "R5";
        else if (ce_n) tag = "R3";
        else if (!we_n) tag = "R2";
        else tag = "R1";
        tests++;
        if (dq_oe !== exp_oe) begin
            fails++;
            $display("FAIL %s per-cycle dq_oe got %b exp %b", tag, dq_oe, exp_oe);
        end
        if (exp_oe && !$isunknown(ref_mem[addr])) begin
            tests++;
            if (dq_out !== ref_mem[addr]) begin
                fails++;
                $display("FAIL %s per-cycle dq_out @%0d got %h exp %h",
                         ref_flag ? "R8" : "R1", addr, dq_out, ref_mem[addr]);
            end
        end else if (!exp_oe) begin
            tests++;
            if (dq_out !== 8'h00) begin
                fails++;
                $display("FAIL R1 idle dq_out got %h exp 00", dq_out);
            end
        end
    end

    task automatic check1(logic got, logic exp, string tag);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %b exp %b", tag, got, exp);
        end
    endtask

    task automatic check8(logic [7:0] got, logic [7:0] exp, string tag);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        ce_n = 1; we_n = 1; oe_n = 1;
    endtask

    task automatic wr(int a, logic [7:0] d, logic oe_v);
        ce_n = 0; we_n = 0; oe_n = oe_v; addr = AW'(a); dq_in = d;
        step();
        idle();
    endtask

    task automatic rd(int a, logic [7:0] exp, string tag);
        ce_n = 0; we_n = 1; oe_n = 0; addr = AW'(a);
        @(negedge clk);
        check1(dq_oe, 1'b1, tag);
        check8(dq_out, exp, tag);
        step();
        idle();
    endtask

    task automatic rd_dark(int a, string tag);
        ce_n = 0; we_n = 1; oe_n = 0; addr = AW'(a);
        @(negedge clk);
        check1(dq_oe, 1'b0, tag);
        step();
        idle();
    endtask

    initial begin
        #700000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R10: reset state.
        repeat (3) step();
        @(negedge clk);
        check1(dq_oe, 1'b0, "R10 reset dq_oe");
        step();
        rst_n = 1;
        repeat (RC) step();

        // Preload every location.
        for (int a = 0; a < 2048; a++) wr(a, pat(a), 1'b1);

        // R1: reads at both ends and in the middle.
        rd(0, pat(0), "R1 read 0");
        rd(5, pat(5), "R1 read 5");
        rd(2047, pat(2047), "R1 read 2047");

        // R2: write with output enable low; no drive during the write.
        ce_n = 0; we_n = 0; oe_n = 0; addr = AW'(100); dq_in = 8'hA5;
        @(negedge clk);
        check1(dq_oe, 1'b0, "R2 no drive in write");
        step(); idle();
        rd(100, 8'hA5, "R2 write with oe_n low");

        // R3: deselected write and read.
        ce_n = 1; we_n = 0; oe_n = 0; addr = AW'(200); dq_in = 8'h3C;
        @(negedge clk);
        check1(dq_oe, 1'b0, "R3 standby dq_oe");
        step(); idle();
        rd(200, pat(200), "R3 deselected write ignored");

        // R4: supply low ignores everything.
        power_good = 0;
        step();
        wr(300, 8'h77, 1'b0);
        rd_dark(300, "R4 read while unpowered");
        // R9: supply drops with a write request.
        power_good = 1;
        repeat (RC) step();
        ce_n = 0; we_n = 0; addr = AW'(400); dq_in = 8'h11; power_good = 0;
        step(); idle();
        power_good = 1;
        repeat (RC) step();
        rd(300, pat(300), "R4 write while unpowered ignored");
        rd(400, pat(400), "R9 drop during write keeps target");
        rd(401, pat(401), "R9 neighbour unchanged");

        // R5: recovery boundary.
        power_good = 0;
        step();
        power_good = 1;
        ce_n = 0; we_n = 0; addr = AW'(500); dq_in = 8'h99;
        step();
        idle();
        ce_n = 0; we_n = 1; oe_n = 0; addr = AW'(500);
        repeat (RC - 2) step();
        @(negedge clk);
        check1(dq_oe, 1'b0, "R5 one cycle before live");
        step();
        @(negedge clk);
        check1(dq_oe, 1'b1, "R5 live at boundary");
        check8(dq_out, pat(500), "R5 write in window ignored");
        step(); idle();

        // R6: battery_low while powered has no effect.
        battery_low = 1;
        wr(602, 8'hC3, 1'b1);
        battery_low = 0;
        rd(602, 8'hC3, "R6 battery_low ignored while powered");

        // R6, R7, R8: flagged restore.
        power_good = 0;
        step();
        power_good = 1; battery_low = 1;
        step();
        battery_low = 0;
        repeat (RC - 1) step();
        rd(601, pat(601), "R8 read with flag set");
        wr(600, 8'h5A, 1'b1);
        rd(600, pat(600), "R6 first write blocked");
        wr(600, 8'h5A, 1'b1);
        rd(600, 8'h5A, "R7 second write stored");
        wr(601, 8'h66, 1'b1);
        rd(601, 8'h66, "R7 later write stored");

        // R10: reset keeps the array.
        rst_n = 0;
        repeat (3) step();
        @(negedge clk);
        check1(dq_oe, 1'b0, "R10 dq_oe in reset");
        step();
        rst_n = 1;
        repeat (RC) step();
        rd(600, 8'h5A, "R10 contents survive reset");
        rd(5, pat(5), "R10 contents survive reset 5");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule